// File: doc/BRIEF.md
# Trace System-Register Access Trap Decoder

This block rules on a software access to a trace system register before that access reaches any register storage. It receives the exception level of the access, whether it is a read or a write, and the trap-control bits of each level. It also receives the presence and register-width facts for EL2 and EL3. From these it produces one of three outcomes: the access is undefined, the access traps to a target exception level with a fixed syndrome class, or the access is allowed.

Each level has its own ordered chain of trap checks, and the first check that applies wins. EL1 has the longest chain. It includes a fine-grained trap whose controlling bit depends on the access direction, and that trap can be blocked by an enable owned by EL3.

A request is a one-cycle `reqValid` pulse with its inputs. The decision is registered, so it appears on the next clock edge together with a one-cycle `rspValid` pulse. The decision then stays on the outputs until another request is accepted.

Top module: `sysreg_trap_decoder`

## Requirements
- R1: A request whose `reqEl` is 0 always gives `rspUndef`=1. This holds for every trap-control and presence input.
- R2: At EL1 (`reqEl`=1), `el1TraceTrap`=1 traps to target level 1. This check takes priority over every other EL1 check.
- R3: At EL1, if R2 does not apply, `el2TraceTrap`=1 traps to level 2. This happens only when `el2Enabled`=1 and `el2Is64`=1; otherwise the bit is ignored.
- R4: At EL1, the fine-grained check comes after R2 and R3 and traps to level 2. It needs `el2Enabled`=1, `el2Is64`=1, and either `el3Present`=0 or `fgtEnable`=1. It tests `fgtReadTrap` when `reqWrite`=0 and `fgtWriteTrap` when `reqWrite`=1.
- R5: At EL1, the last check is `el3TraceTrap`=1, which traps to level 3. It applies only when `el3Present`=1 and `el3Is64`=1.
- R6: At EL2 (`reqEl`=2), `el2TraceTrap`=1 traps to level 2. Otherwise, `el3TraceTrap`=1 traps to level 3 when `el3Present`=1 and `el3Is64`=1. The EL1 and fine-grained bits are ignored.
- R7: At EL3 (`reqEl`=3), only `el3TraceTrap` counts: when it is 1 the access traps to level 3, and when it is 0 the access is permitted.
- R8: A trap drives `rspClass`=0x18. When `rspTrap`=0, both `rspClass` and `rspTargetEl` are 0.
- R9: When no check applies, `rspPermit`=1. After any request, exactly one of `rspUndef`, `rspTrap` and `rspPermit` is 1.
- R10: The result appears on the clock edge after a request, with `rspValid` high for that one cycle. The result then holds unchanged, with `rspValid`=0, until the next request.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqEl | input | 2 | Exception level of the access |
| el1TraceTrap | input | 1 | EL1 trace-access trap control |
| el2TraceTrap | input | 1 | EL2 trace-access trap control |
| el3TraceTrap | input | 1 | EL3 trace-access trap control |
| fgtReadTrap | input | 1 | Fine-grained trap bit for reads |
| fgtWriteTrap | input | 1 | Fine-grained trap bit for writes |
| fgtEnable | input | 1 | EL3 enable for fine-grained traps |
| el2Enabled | input | 1 | EL2 is enabled |
| el2Is64 | input | 1 | EL2 uses 64-bit state |
| el3Present | input | 1 | EL3 is implemented |
| el3Is64 | input | 1 | EL3 uses 64-bit state |
| rspValid | output | 1 | One-cycle pulse when a new result is loaded |
| rspUndef | output | 1 | Access is undefined |
| rspTrap | output | 1 | Access traps |
| rspPermit | output | 1 | Access is permitted |
| rspTargetEl | output | 2 | Trap target level (0 unless trapping) |
| rspClass | output | 6 | Syndrome class (0 unless trapping) |

## Verification
The hardest cases sit deep in the EL1 chain. Reaching the fine-grained trap needs R2 and R3 both inactive. It also needs EL2 live, and needs EL3 either absent or with `fgtEnable` set. The direction-selected bit must be set while the opposite bit is clear, and the EL3 bit has to be set alongside to show that it loses on priority. Directed tasks build each of these combinations explicitly. A final sweep drives all 8192 combinations of level, direction and control bits back to back and compares every result against a reference model written from the requirements.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;
  localparam int EL_W = 2;

  typedef enum logic [EL_W-1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2,
    LVL3 = 2'd3
  } excLevel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    logic      undef;
    logic      trap;
    excLevel_e targetEl;
  } trapStrobe_t;
endpackage

// File: rtl/sysreg_trap_ctrl.sv
module sysreg_trap_ctrl
  import sysreg_trap_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqWrite,
  input  excLevel_e   reqEl,
  input  logic        el1TraceTrap,
  input  logic        el2TraceTrap,
  input  logic        el3TraceTrap,
  input  logic        fgtReadTrap,
  input  logic        fgtWriteTrap,
  input  logic        fgtEnable,
  input  logic        el2Enabled,
  input  logic        el2Is64,
  input  logic        el3Present,
  input  logic        el3Is64,
  output trapStrobe_t strobe
);
  logic el2Live, el3Live, fgtBit, fgtLive;

  assign el2Live = el2Enabled && el2Is64;
  assign el3Live = el3Present && el3Is64;
  assign fgtBit  = reqWrite ? fgtWriteTrap : fgtReadTrap;
  assign fgtLive = el2Live && (!el3Present || fgtEnable) && fgtBit;

  always_comb begin
    strobe          = '0;
    strobe.load     = reqValid;
    strobe.targetEl = LVL0;
    unique case (reqEl)
      LVL0: strobe.undef = 1'b1;
      LVL1: begin
        if (el1TraceTrap) begin
          strobe.trap = 1'b1; strobe.targetEl = LVL1;
        end else if (el2Live && el2TraceTrap) begin
          strobe.trap = 1'b1; strobe.targetEl = LVL2;
        end else if (fgtLive) begin
          strobe.trap = 1'b1; strobe.targetEl = LVL2;
        end else if (el3Live && el3TraceTrap) begin
          strobe.trap = 1'b1; strobe.targetEl = LVL3;
        end
      end
      LVL2: begin
        if (el2TraceTrap) begin
          strobe.trap = 1'b1; strobe.targetEl = LVL2;
        end else if (el3Live && el3TraceTrap) begin
          strobe.trap = 1'b1; strobe.targetEl = LVL3;
        end
      end
      LVL3: begin
        if (el3TraceTrap) begin
          strobe.trap = 1'b1; strobe.targetEl = LVL3;
        end
      end
      default: strobe.undef = 1'b1;
    endcase
  end
endmodule

// File: rtl/sysreg_trap_dp.sv
module sysreg_trap_dp
  import sysreg_trap_pkg::*;
#(
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = CLASS_W'('h18)
) (
  input  logic               clk,
  input  logic               rstN,
  input  trapStrobe_t        strobe,
  output logic               rspValid,
  output logic               rspUndef,
  output logic               rspTrap,
  output logic               rspPermit,
  output logic [EL_W-1:0]    rspTargetEl,
  output logic [CLASS_W-1:0] rspClass
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspUndef    <= 1'b0;
      rspTrap     <= 1'b0;
      rspPermit   <= 1'b0;
      rspTargetEl <= '0;
      rspClass    <= '0;
    end else begin
      rspValid <= strobe.load;
      if (strobe.load) begin
        rspUndef    <= strobe.undef;
        rspTrap     <= strobe.trap;
        rspPermit   <= !strobe.undef && !strobe.trap;
        rspTargetEl <= strobe.trap ? strobe.targetEl : '0;
        rspClass    <= strobe.trap ? TRAP_CLASS : '0;
      end
    end
  end
endmodule

// File: rtl/sysreg_trap_decoder.sv
module sysreg_trap_decoder
  import sysreg_trap_pkg::*;
#(
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = CLASS_W'('h18)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [1:0]         reqEl,
  input  logic               el1TraceTrap,
  input  logic               el2TraceTrap,
  input  logic               el3TraceTrap,
  input  logic               fgtReadTrap,
  input  logic               fgtWriteTrap,
  input  logic               fgtEnable,
  input  logic               el2Enabled,
  input  logic               el2Is64,
  input  logic               el3Present,
  input  logic               el3Is64,
  output logic               rspValid,
  output logic               rspUndef,
  output logic               rspTrap,
  output logic               rspPermit,
  output logic [1:0]         rspTargetEl,
  output logic [CLASS_W-1:0] rspClass
);
  trapStrobe_t strobe;

  sysreg_trap_ctrl u_ctrl (
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqEl        (excLevel_e'(reqEl)),
    .el1TraceTrap (el1TraceTrap),
    .el2TraceTrap (el2TraceTrap),
    .el3TraceTrap (el3TraceTrap),
    .fgtReadTrap  (fgtReadTrap),
    .fgtWriteTrap (fgtWriteTrap),
    .fgtEnable    (fgtEnable),
    .el2Enabled   (el2Enabled),
    .el2Is64      (el2Is64),
    .el3Present   (el3Present),
    .el3Is64      (el3Is64),
    .strobe       (strobe)
  );

  sysreg_trap_dp #(.CLASS_W(CLASS_W), .TRAP_CLASS(TRAP_CLASS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rspValid    (rspValid),
    .rspUndef    (rspUndef),
    .rspTrap     (rspTrap),
    .rspPermit   (rspPermit),
    .rspTargetEl (rspTargetEl),
    .rspClass    (rspClass)
  );
endmodule

// File: rtl/sysreg_trap_chk.sv
module sysreg_trap_chk #(
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = CLASS_W'('h18)
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [1:0]         reqEl,
  input logic               el3TraceTrap,
  input logic               rspValid,
  input logic               rspUndef,
  input logic               rspTrap,
  input logic               rspPermit,
  input logic [1:0]         rspTargetEl,
  input logic [CLASS_W-1:0] rspClass
);
  // R1
  el0_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqEl == 2'd0) |=> rspUndef);
  // R7
  el3_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqEl == 2'd3) |=>
      (el3TraceTrap_q ? (rspTrap && rspTargetEl == 2'd3) : rspPermit));
  // R8
  trap_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspTrap |-> (rspClass == TRAP_CLASS && rspTargetEl != 2'd0));
  // R8
  quiet_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspTrap |-> (rspClass == '0 && rspTargetEl == 2'd0));
  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspUndef, rspTrap, rspPermit}) == 1);
  // R9
  at_most_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspUndef, rspTrap, rspPermit}));
  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && $stable({rspUndef, rspTrap, rspPermit, rspTargetEl, rspClass})));

  logic el3TraceTrap_q;
  always_ff @(posedge clk) el3TraceTrap_q <= el3TraceTrap;
endmodule

bind sysreg_trap_decoder sysreg_trap_chk #(.CLASS_W(CLASS_W), .TRAP_CLASS(TRAP_CLASS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqEl        (reqEl),
  .el3TraceTrap (el3TraceTrap),
  .rspValid     (rspValid),
  .rspUndef     (rspUndef),
  .rspTrap      (rspTrap),
  .rspPermit    (rspPermit),
  .rspTargetEl  (rspTargetEl),
  .rspClass     (rspClass)
);

// File: tb/test_sysreg_trap_decoder.sv
module test_sysreg_trap_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqEl = 2'd0;
  logic el1TraceTrap = 0, el2TraceTrap = 0, el3TraceTrap = 0;
  logic fgtReadTrap = 0, fgtWriteTrap = 0, fgtEnable = 0;
  logic el2Enabled = 0, el2Is64 = 0, el3Present = 0, el3Is64 = 0;
  logic rspValid, rspUndef, rspTrap, rspPermit;
  logic [1:0] rspTargetEl;
  logic [5:0] rspClass;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  sysreg_trap_decoder i_sysreg_trap_decoder (.*);

  // packed result: {valid, undef, trap, permit, target[1:0], class[5:0]}
  function automatic logic [11:0] refModel();
    logic el2L, el3L, fg;
    logic [1:0] t;
    el2L = el2Enabled && el2Is64;
    el3L = el3Present && el3Is64;
    fg = el2L && (!el3Present || fgtEnable) && (reqWrite ? fgtWriteTrap : fgtReadTrap);
    t = 2'd0;
    case (reqEl)
      2'd0: return {1'b1, 3'b100, 2'd0, 6'd0};
      2'd1: if (el1TraceTrap) t = 2'd1;
            else if (el2L && el2TraceTrap) t = 2'd2;
            else if (fg) t = 2'd2;
            else if (el3L && el3TraceTrap) t = 2'd3;
      2'd2: if (el2TraceTrap) t = 2'd2;
            else if (el3L && el3TraceTrap) t = 2'd3;
      default: if (el3TraceTrap) t = 2'd3;
    endcase
    if (t != 2'd0) return {1'b1, 3'b010, t, 6'h18};
    return {1'b1, 3'b001, 2'd0, 6'd0};
  endfunction

  function automatic logic [11:0] actual();
    return {rspValid, rspUndef, rspTrap, rspPermit, rspTargetEl, rspClass};
  endfunction

  task automatic compare(string tag, logic [11:0] exp);
    checks++;
    if (actual() !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  task automatic setCfg(logic [12:0] v);
    {reqEl, reqWrite, el1TraceTrap, el2TraceTrap, el3TraceTrap, fgtReadTrap,
     fgtWriteTrap, fgtEnable, el2Enabled, el2Is64, el3Present, el3Is64} = v;
  endtask

  // issue one request and check the registered result
  task automatic issue(string tag, logic [12:0] v);
    logic [11:0] exp;
    @(negedge clk);
    setCfg(v);
    reqValid = 1'b1;
    exp = refModel();
    @(negedge clk);
    reqValid = 1'b0;
    compare(tag, exp);
  endtask

  // cfg fields: el,wr,t1,t2,t3,fr,fw,fen,e2en,e2_64,e3p,e3_64
  function automatic logic [12:0] mk(int el, bit wr, bit t1, bit t2, bit t3, bit fr, bit fw,
                                     bit fen, bit e2en, bit e264, bit e3p, bit e364);
    return {2'(el), wr, t1, t2, t3, fr, fw, fen, e2en, e264, e3p, e364};
  endfunction

  task automatic testReset();
    compare("R11 reset", 12'h000);
  endtask

  task automatic testEl0();
    issue("R1 el0 all set", mk(0,1,1,1,1,1,1,1,1,1,1,1));
    compare("R1 el0 value", {1'b0, 3'b100, 2'd0, 6'd0} | 12'h800);
    issue("R1 el0 none", mk(0,0,0,0,0,0,0,0,0,0,0,0));
  endtask

  task automatic testEl1Chain();
    issue("R2 el1 bit wins", mk(1,0,1,1,1,1,1,1,1,1,1,1));
    compare("R2 target1", {1'b1, 3'b010, 2'd1, 6'h18});
    issue("R3 el2 bit", mk(1,0,0,1,1,0,0,0,1,1,1,1));
    compare("R3 target2", {1'b1, 3'b010, 2'd2, 6'h18});
    issue("R3 el2 disabled ignored", mk(1,0,0,1,0,0,0,0,0,1,0,0));
    compare("R3 permit", {1'b1, 3'b001, 2'd0, 6'd0});
    issue("R3 el2 32bit ignored", mk(1,0,0,1,0,0,0,0,1,0,0,0));
    issue("R5 el3 bit", mk(1,0,0,0,1,0,0,0,0,0,1,1));
    compare("R5 target3", {1'b1, 3'b010, 2'd3, 6'h18});
    issue("R5 el3 32bit ignored", mk(1,0,0,0,1,0,0,0,0,0,1,0));
    compare("R5 permit", {1'b1, 3'b001, 2'd0, 6'd0});
  endtask

  task automatic testFineGrained();
    issue("R4 read bit read", mk(1,0,0,0,1,1,0,1,1,1,1,1));
    compare("R4 read trap2", {1'b1, 3'b010, 2'd2, 6'h18});
    issue("R4 write bit on read", mk(1,0,0,0,0,0,1,1,1,1,1,1));
    compare("R4 read permit", {1'b1, 3'b001, 2'd0, 6'd0});
    issue("R4 write bit write", mk(1,1,0,0,0,0,1,1,1,1,1,1));
    compare("R4 write trap2", {1'b1, 3'b010, 2'd2, 6'h18});
    issue("R4 read bit on write", mk(1,1,0,0,0,1,0,1,1,1,1,1));
    issue("R4 blocked by el3 enable", mk(1,0,0,0,1,1,1,0,1,1,1,1));
    compare("R4 falls to el3", {1'b1, 3'b010, 2'd3, 6'h18});
    issue("R4 el3 absent", mk(1,1,0,0,0,1,1,0,1,1,0,0));
    compare("R4 absent trap2", {1'b1, 3'b010, 2'd2, 6'h18});
  endtask

  task automatic testEl2El3();
    issue("R6 el2 bit", mk(2,0,1,1,1,1,1,1,0,0,1,1));
    compare("R6 target2", {1'b1, 3'b010, 2'd2, 6'h18});
    issue("R6 el3 bit", mk(2,0,1,0,1,1,1,1,1,1,1,1));
    compare("R6 target3", {1'b1, 3'b010, 2'd3, 6'h18});
    issue("R6 ignores el1 fgt", mk(2,1,1,0,0,1,1,1,1,1,1,1));
    compare("R6 permit", {1'b1, 3'b001, 2'd0, 6'd0});
    issue("R7 el3 bit", mk(3,0,0,0,1,0,0,0,0,0,0,0));
    compare("R7 target3", {1'b1, 3'b010, 2'd3, 6'h18});
    issue("R7 others ignored", mk(3,1,1,1,0,1,1,1,1,1,1,1));
    compare("R7 permit", {1'b1, 3'b001, 2'd0, 6'd0});
  endtask

  task automatic testHold();
    logic [11:0] held;
    issue("R10 load", mk(1,0,0,0,1,0,0,0,0,0,1,1));
    held = actual() & 12'h7FF;
    @(negedge clk);
    setCfg(mk(0,1,1,1,1,1,1,1,1,1,1,1));
    repeat (3) @(negedge clk);
    compare("R10 hold", held);
  endtask

  task automatic testSweep();
    for (int v = 0; v < 8192; v++) issue("R9 sweep", 13'(v));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEl0();
    testEl1Chain();
    testFineGrained();
    testEl2El3();
    testHold();
    testSweep();
    finishRun();
  end
endmodule